// File: doc/BRIEF.md
# Bridge Error Status and First-Fault Log Register

This block is the 16-bit error status word of a bus bridge. The bridge datapath sends it single-cycle pulses. Some pulses report split completion messages, each with a class code and an 8-bit message index. Others report dropped interrupt messages, uncorrectable errors in a data phase or in an address/attribute phase, discarded posted writes, and observed parity errors. Each condition is held in a sticky flag. For the first completer-error message that is not a plain write data error, the block records the message index, and it keeps that index until software releases it.

The record is controlled by a two-state machine. In `CAP_EMPTY` no index is held. The transition `CAP_EMPTY -> CAP_HELD` happens on the first qualifying message and loads its index. The transition `CAP_HELD -> CAP_EMPTY` happens when software writes 1 to the release bit and no new qualifying message arrives in that cycle. If a qualifying message and a release arrive in the same cycle, the machine goes to or stays in `CAP_HELD` and loads the new index. In all other cases the state does not change.

Software uses a 16-bit write strobe and a read strobe. Read data appears one cycle after the read strobe. The power-good reset clears all status. The link reset clears only the read-data register and leaves all status intact. A log-clear input, active low, puts three of the flags into a one-cycle pulse mode.

Top module: `errlog_status_reg`

## Requirements
- R1: Bit 15 sets when a class-2 completion message arrives with index 0x80 to 0x8F (upper nibble 8). Writing 1 to bit 15 clears it.
- R2: A class-2 completion message with an index other than 1 sets bit 9 if bit 9 is clear. That message's index is then shown with index[7:5] in bits 12:10 and index[4:0] in bits 8:4. Messages of any other class, and class-2 messages with index 1, leave bit 9 and the index fields unchanged.
- R3: Writing 1 to bit 9 does not affect bit 9 or the index fields. Writing 1 to bit 13 clears bit 9. Bit 13 always reads 0.
- R4: While bit 9 is set, later qualifying messages do not change the recorded index.
- R5: When bit 9 is clear, bits 12:10 and 8:4 read 0.
- R6: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set. A release of bit 9 in the same cycle as a qualifying message records the new message's index.
- R7: Bits 14 (dropped interrupt), 3 (data-phase error), 2 (address/attribute error), 1 (discarded posted write) and 0 (parity error observed) set on their event pulses and clear when 1 is written to them. Bit 0 sets on every parity observation pulse, whichever agent drove the parity error.
- R8: While `log_clr_n` is 0, bits 3, 2 and 1 read 1 only in the cycle after their event and are 0 in the cycle after that unless the event repeats. Bits 14 and 0 do not respond to `log_clr_n`.
- R9: Asserting `pwr_rst_n` low clears every bit. Asserting `link_rst_n` low leaves every status bit unchanged and forces only `reg_rd_data` to 0. `reg_rd_data` shows the register value one cycle after `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-good reset, active low, asynchronous; clears all status |
| link_rst_n | input | 1 | Link reset, active low, asynchronous; clears read data only |
| log_clr_n | input | 1 | Log clear, active low; bits 3..1 become one-cycle pulses |
| scm_valid | input | 1 | Split completion message pulse |
| scm_class | input | 2 | Class code of the completion message |
| scm_index | input | 8 | Message index of the completion message |
| msi_drop | input | 1 | Interrupt message dropped |
| data_err | input | 1 | Uncorrectable error in completion data phase |
| addr_err | input | 1 | Uncorrectable error in address/attribute phase |
| post_discard | input | 1 | Posted write discarded (abort or data error) |
| perr_seen | input | 1 | Parity error line observed asserted |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Write data; 1 bits clear flags, bit 13 releases the index |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_data | output | 16 | Registered read data |

## Verification
The message decoder is driven with several indices. 0x5A sets only the record. 0x83 and 0x8F set the device-specific flag as well. Index 0x01 with class 2, and index 0x80 with class 1, must change nothing. Together these cases separate the class test, the index-1 exclusion and the nibble match. A second qualifying message is sent while an index is held, which shows whether the record keeps the first index or the latest one. Writes that clear a flag in the same cycle as an event on that flag show the priority between set and clear. Event pulses sent while log-clear is low, followed by reads on two consecutive cycles, separate the pulse-mode flags from the ordinary sticky flags. The bench also confirms that status survives a link reset and that a power-good reset clears it.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int REG_W     = 16;
    localparam int IDX_W     = 8;
    localparam int CLS_W     = 2;
    localparam int IDX_HI_W  = 3;
    localparam int IDX_LO_W  = IDX_W - IDX_HI_W;

    // bit positions software decodes
    localparam int B_DEVSPEC   = 15;
    localparam int B_MSI_DROP  = 14;
    localparam int B_RELEASE   = 13;
    localparam int B_IDX_HI    = 10;
    localparam int B_CAP_VLD   = 9;
    localparam int B_IDX_LO    = 4;
    localparam int B_DATA_ERR  = 3;
    localparam int B_ADDR_ERR  = 2;
    localparam int B_POST_DISC = 1;
    localparam int B_PERR      = 0;

    // sticky flags handled by the generic flag cell
    localparam int NFLAG = 6;

    typedef enum logic {
        CAP_EMPTY = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_t;

    // flag slot -> register bit
    function automatic int flag_pos(input int i);
        case (i)
            0:       return B_PERR;
            1:       return B_POST_DISC;
            2:       return B_ADDR_ERR;
            3:       return B_DATA_ERR;
            4:       return B_MSI_DROP;
            default: return B_DEVSPEC;
        endcase
    endfunction

    // flag slot -> responds to log clear
    function automatic bit flag_auto(input int i);
        return (i >= 1) && (i <= 3);
    endfunction

endpackage

// File: rtl/errlog_scm_decode.sv
module errlog_scm_decode #(
    parameter int CLS_W        = 2,
    parameter int IDX_W        = 8,
    parameter int CMPL_CLASS   = 2,
    parameter int DATA_ERR_IDX = 1,
    parameter int DEVSPEC_NIB  = 8
) (
    input  logic             scm_valid,
    input  logic [CLS_W-1:0] scm_class,
    input  logic [IDX_W-1:0] scm_index,
    output logic             qual,
    output logic             devspec
);
    localparam int NIB_W = 4;

    logic is_cmpl;

    always_comb begin
        is_cmpl = scm_valid && (scm_class == CLS_W'(CMPL_CLASS));
        qual    = is_cmpl && (scm_index != IDX_W'(DATA_ERR_IDX));
        devspec = is_cmpl &&
                  (scm_index[IDX_W-1 -: NIB_W] == NIB_W'(DEVSPEC_NIB));
    end

endmodule

// File: rtl/errlog_flag.sv
module errlog_flag #(
    parameter bit AUTO_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic w1c,
    input  logic log_clr_n,
    output logic q
);
    logic auto_act;

    assign auto_act = AUTO_CLR && !log_clr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (auto_act)
            q <= set;
        else if (set)
            q <= 1'b1;
        else if (w1c)
            q <= 1'b0;
    end

    // R6: an event always leaves the flag set
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    // R7: a clear with no event empties the flag
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !set) |=> !q);

    // R8: in pulse mode the flag drops without a fresh event
    assert_auto_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (AUTO_CLR && !log_clr_n && !set) |=> !q);

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             release_req,
    output logic             held,
    output logic [IDX_W-1:0] idx_out
);
    cap_state_t       state, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic             load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CAP_EMPTY;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            CAP_EMPTY: begin
                if (qual) begin
                    state_nx = CAP_HELD;
                    load     = 1'b1;
                end
            end
            CAP_HELD: begin
                if (release_req && qual) begin
                    state_nx = CAP_HELD;
                    load     = 1'b1;
                end else if (release_req) begin
                    state_nx = CAP_EMPTY;
                end
            end
            default: state_nx = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (load)
            idx_q <= idx_in;
    end

    // outputs
    always_comb begin
        held    = (state == CAP_HELD);
        idx_out = held ? idx_q : '0;
    end

    // R4: a held index stays put unless released
    assert_hold_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_HELD && !release_req) |=> (state == CAP_HELD) && $stable(idx_q));

    // R3: release without a new message empties the record
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && !qual) |=> (state == CAP_EMPTY));

    // R6: a message in the release cycle is recorded
    assert_release_race_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && qual) |=> (state == CAP_HELD) && (idx_q == $past(idx_in)));

endmodule

// File: rtl/errlog_status_reg.sv
module errlog_status_reg
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              pwr_rst_n,
    input  logic              link_rst_n,
    input  logic              log_clr_n,
    input  logic              scm_valid,
    input  logic [CLS_W-1:0]  scm_class,
    input  logic [IDX_W-1:0]  scm_index,
    input  logic              msi_drop,
    input  logic              data_err,
    input  logic              addr_err,
    input  logic              post_discard,
    input  logic              perr_seen,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic              reg_rd_en,
    output logic [REG_W-1:0]  reg_rd_data
);
    logic             cmpl_qual;
    logic             cmpl_devspec;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_q;
    logic             cap_held;
    logic [IDX_W-1:0] cap_idx;
    logic             rel_req;
    logic [REG_W-1:0] status_word;

    errlog_scm_decode #(
        .CLS_W(CLS_W),
        .IDX_W(IDX_W)
    ) u_decode (
        .scm_valid (scm_valid),
        .scm_class (scm_class),
        .scm_index (scm_index),
        .qual      (cmpl_qual),
        .devspec   (cmpl_devspec)
    );

    assign flag_set = {cmpl_devspec, msi_drop, data_err, addr_err, post_discard, perr_seen};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        errlog_flag #(
            .AUTO_CLR(flag_auto(g))
        ) u_flag (
            .clk       (clk),
            .rst_n     (pwr_rst_n),
            .set       (flag_set[g]),
            .w1c       (reg_wr_en && reg_wr_data[flag_pos(g)]),
            .log_clr_n (log_clr_n),
            .q         (flag_q[g])
        );
    end

    assign rel_req = reg_wr_en && reg_wr_data[B_RELEASE];

    errlog_capture #(
        .IDX_W(IDX_W)
    ) u_capture (
        .clk         (clk),
        .rst_n       (pwr_rst_n),
        .qual        (cmpl_qual),
        .idx_in      (scm_index),
        .release_req (rel_req),
        .held        (cap_held),
        .idx_out     (cap_idx)
    );

    always_comb begin
        status_word = '0;
        for (int i = 0; i < NFLAG; i++)
            status_word[flag_pos(i)] = flag_q[i];
        status_word[B_CAP_VLD] = cap_held;
        status_word[B_IDX_HI +: IDX_HI_W] = cap_idx[IDX_W-1 -: IDX_HI_W];
        status_word[B_IDX_LO +: IDX_LO_W] = cap_idx[IDX_LO_W-1:0];
    end

    always_ff @(posedge clk or negedge link_rst_n) begin
        if (!link_rst_n)
            reg_rd_data <= '0;
        else if (reg_rd_en)
            reg_rd_data <= status_word;
    end

    // R3: release bit never reads back as 1
    assert_release_zero_R3: assert property (@(posedge clk) disable iff (!link_rst_n)
        reg_rd_data[B_RELEASE] == 1'b0);

    // R5: index fields are empty when no index is held
    assert_idx_zero_R5: assert property (@(posedge clk) disable iff (!link_rst_n || !pwr_rst_n)
        !reg_rd_data[B_CAP_VLD] |->
            (reg_rd_data[B_IDX_HI +: IDX_HI_W] == '0) && (reg_rd_data[B_IDX_LO +: IDX_LO_W] == '0));

    // R9: a read returns the word as it stood at the strobe
    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!link_rst_n || !pwr_rst_n)
        reg_rd_en |=> reg_rd_data == $past(status_word));

endmodule

// File: tb/tb_errlog_status_reg.sv
`timescale 1ns/1ps
module tb_errlog_status_reg;

    logic        clk = 1'b0;
    logic        pwr_rst_n = 1'b0;
    logic        link_rst_n = 1'b0;
    logic        log_clr_n = 1'b1;
    logic        scm_valid = 1'b0;
    logic [1:0]  scm_class = '0;
    logic [7:0]  scm_index = '0;
    logic        msi_drop = 1'b0;
    logic        data_err = 1'b0;
    logic        addr_err = 1'b0;
    logic        post_discard = 1'b0;
    logic        perr_seen = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [15:0] reg_rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_issued = 1'b0;

    always #10 clk = ~clk;

    errlog_status_reg dut (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .link_rst_n(link_rst_n),
        .log_clr_n(log_clr_n), .scm_valid(scm_valid), .scm_class(scm_class),
        .scm_index(scm_index), .msi_drop(msi_drop), .data_err(data_err),
        .addr_err(addr_err), .post_discard(post_discard), .perr_seen(perr_seen),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each read result one cycle after the strobe
    always @(posedge clk) rd_issued <= reg_rd_en;

    always @(negedge clk) begin
        if (rd_issued) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard empty actual=%h expected=none", reg_rd_data);
            end else begin
                check(tag_q.pop_front(), reg_rd_data, exp_q.pop_front());
            end
        end
    end

    // one cycle of stimulus; ev = {msi, data, addr, post, perr}
    task automatic step(input logic we, input logic [15:0] wd,
                        input logic sv, input logic [1:0] cls, input logic [7:0] idx,
                        input logic [4:0] ev);
        reg_wr_en = we; reg_wr_data = wd;
        scm_valid = sv; scm_class = cls; scm_index = idx;
        {msi_drop, data_err, addr_err, post_discard, perr_seen} = ev;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0; scm_valid = 1'b0;
        {msi_drop, data_err, addr_err, post_discard, perr_seen} = '0;
    endtask

    task automatic rd(input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        step(1'b1, d, 1'b0, 2'd0, 8'd0, 5'd0);
    endtask

    task automatic msg(input logic [1:0] cls, input logic [7:0] idx);
        step(1'b0, 16'h0, 1'b1, cls, idx, 5'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        pwr_rst_n = 1'b1; link_rst_n = 1'b1;
        @(negedge clk);
        rd(16'h0000, "R9 reset state");

        msg(2'd2, 8'h5A);
        rd(16'h0BA0, "R2 first capture 0x5A");
        msg(2'd2, 8'h83);
        rd(16'h8BA0, "R1/R4 devspec set, index kept");
        msg(2'd2, 8'h01);
        msg(2'd1, 8'h80);
        rd(16'h8BA0, "R2 index 1 and class 1 ignored");
        wr(16'h0200);
        rd(16'h8BA0, "R3 write to bit 9 no effect");
        wr(16'h8000);
        rd(16'h0BA0, "R1 w1c bit 15");
        wr(16'h2000);
        rd(16'h0000, "R3/R5 release clears record");
        msg(2'd2, 8'h8F);
        rd(16'h92F0, "R1/R2 capture 0x8F");
        step(1'b0, 16'h0, 1'b0, 2'd0, 8'd0, 5'b11111);
        rd(16'hD2FF, "R7 all events set");
        wr(16'h4005);
        rd(16'h92FA, "R7 w1c bits 14,2,0");
        step(1'b1, 16'h0002, 1'b0, 2'd0, 8'd0, 5'b00010);
        rd(16'h92FA, "R6 set beats w1c");
        step(1'b1, 16'h2000, 1'b1, 2'd2, 8'h10, 5'd0);
        rd(16'h830A, "R6 release with new message");

        link_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 read data during link reset", reg_rd_data, 16'h0000);
        link_rst_n = 1'b1;
        @(negedge clk);
        rd(16'h830A, "R9 state kept over link reset");

        wr(16'hE00F);
        rd(16'h0000, "R7 clear all");

        log_clr_n = 1'b0;
        step(1'b0, 16'h0, 1'b0, 2'd0, 8'd0, 5'b11111);
        rd(16'h400F, "R8 pulse visible one cycle");
        rd(16'h4001, "R8 bits 3..1 self cleared");
        log_clr_n = 1'b1;
        wr(16'h4001);
        rd(16'h0000, "R7 clear after log mode");

        msg(2'd2, 8'h84);
        step(1'b0, 16'h0, 1'b0, 2'd0, 8'd0, 5'b01111);
        pwr_rst_n = 1'b0;
        @(negedge clk);
        pwr_rst_n = 1'b1;
        @(negedge clk);
        rd(16'h0000, "R9 power-good reset clears");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 16'(exp_q.size()), 16'h0000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule